// File: doc/BRIEF.md
# Processor Power State Controller

This block tracks the power state of a multi-core processor (two cores by default) across five settled states: running, halted, deep halted (lowered operating point), stop-granted, and deep stop-granted. Its inputs are per-core halt requests, a stop-clock request, a processor reset, returns from the system-management interrupt handler, break events and two enable bits for the deep variants. It reports the settled state as a one-hot vector. It also reports whether bus snoops may be serviced.

When a stop-clock request arrives, the controller asks the bus unit to issue the acknowledge special cycle. It then waits for that cycle's response phase and counts a fixed number of bus clocks before it declares the grant state. Entry to and exit from deep halt are sequenced by a separate operating-point block through a level request and a done pulse. All state changes happen on the rising edge of the bus clock.

Top module: `pwr_state_ctl`

## Requirements
- R1: After `rst_n` is released, `pstate` is 5'b00001 (running), and `snoop_ok`, `ack_cycle_req` and `opp_req` are all 0. The `pstate` bit positions are: bit0 running, bit1 halted, bit2 deep halted, bit3 stop-granted, bit4 deep stop-granted.
- R2: While not every core requests halt, the state stays running. When all cores request halt and `deep_halt_en` is 0, the state becomes halted on the next edge. Halted is left for running on `break_evt`.
- R3: When all cores request halt and `deep_halt_en` is 1, the controller raises `opp_req` with `opp_low`=1 while reporting halted. On `opp_done` it reports deep halted and drops `opp_req`.
- R4: A `break_evt` (or `cpu_reset`) in deep halt raises `opp_req` with `opp_low`=0. The state stays deep halted until `opp_done`, then becomes running.
- R5: `snoop_ok` is 1 exactly while the reported state is halted or deep halted.
- R6: A system-management return (`smi_ret`) taken while running or halted moves to halted when `smi_to_halt` is 1, and to running when it is 0.
- R7: `stop_clk_req` seen while running or halted raises `ack_cycle_req` on the next edge. The request is held until `ack_resp`, and the reported state stays the prior one.
- R8: The grant state is reported exactly GRANT_DLY (default 20) edges after the edge that samples `ack_resp`. A repeated `ack_resp` during the wait restarts the count.
- R9: The deep stop-granted state replaces stop-granted when `deep_grant_en` is 1 at the entry edge.
- R10: Dropping `stop_clk_req` in a grant state returns to halted if the request was taken from halted, and to running otherwise. Dropping it before grant entry aborts to that same prior state.
- R11: `cpu_reset` in a grant state leaves the state unchanged but clears the remembered halt, so a later stop-clock release returns to running. While running, halted or waiting for the grant, it forces running.
- R12: `pstate` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| halt_req | input | N_CORES | Per-core halt request, level |
| deep_halt_en | input | 1 | Enables the deep halt variant |
| deep_grant_en | input | 1 | Enables the deep stop-grant variant |
| stop_clk_req | input | 1 | Stop-clock request, level |
| ack_resp | input | 1 | Response-phase pulse of the acknowledge cycle |
| cpu_reset | input | 1 | Processor reset, reinitialises status |
| smi_ret | input | 1 | Return from the management interrupt handler, pulse |
| smi_to_halt | input | 1 | Return target: 1 halted, 0 running |
| break_evt | input | 1 | Break event pulse |
| opp_done | input | 1 | Operating-point transition finished, pulse |
| pstate | output | 5 | One-hot settled state |
| snoop_ok | output | 1 | Snoops may be serviced |
| ack_cycle_req | output | 1 | Request to issue the acknowledge special cycle |
| opp_req | output | 1 | Operating-point transition request |
| opp_low | output | 1 | Requested target: 1 low point, 0 original |

## Verification
The bench builds the block with its defaults, two cores and a 20-clock grant delay. With these values, all four halt-request patterns can be swept against both deep-halt settings. The grant entry can be exercised from both prior states with both deep-grant settings. Because the delay is short, a repeated response can be injected at every offset inside the wait window, from 1 to 19 clocks, and the exact entry edge checked each time.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

    localparam int unsigned PST_W = 5;
    localparam int unsigned ST_RUN    = 0;
    localparam int unsigned ST_HALT   = 1;
    localparam int unsigned ST_DHALT  = 2;
    localparam int unsigned ST_GRANT  = 3;
    localparam int unsigned ST_DGRANT = 4;

    typedef enum logic [3:0] {
        PH_RUN,
        PH_HALT,
        PH_DH_IN,
        PH_DHALT,
        PH_DH_OUT,
        PH_ACK,
        PH_WAIT,
        PH_GRANT,
        PH_DGRANT
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   ret_halt;
    } ctl_s;

endpackage

// File: rtl/halt_join.sv
module halt_join #(
    parameter int unsigned N_CORES = 2
) (
    input  logic [N_CORES-1:0] req,
    output logic               all_set
);
    logic [N_CORES:0] acc;
    assign acc[0] = 1'b1;

    for (genvar g = 0; g < N_CORES; g++) begin : g_and
        assign acc[g+1] = acc[g] & req[g];
    end

    assign all_set = acc[N_CORES];
endmodule

// File: rtl/grant_timer.sv
module grant_timer #(
    parameter int unsigned GRANT_DLY = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int unsigned CNT_W = (GRANT_DLY > 2) ? $clog2(GRANT_DLY) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GRANT_DLY - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = '0;
        end else if (run && cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/pstate_decode.sv
module pstate_decode
    import pwr_state_pkg::*;
(
    input  phase_e             phase,
    output logic [PST_W-1:0]   pstate
);
    always_comb begin
        pstate = '0;
        case (phase)
            PH_HALT, PH_DH_IN:   pstate[ST_HALT]   = 1'b1;
            PH_DHALT, PH_DH_OUT: pstate[ST_DHALT]  = 1'b1;
            PH_GRANT:            pstate[ST_GRANT]  = 1'b1;
            PH_DGRANT:           pstate[ST_DGRANT] = 1'b1;
            PH_ACK, PH_WAIT:     pstate = '0;
            default:             pstate[ST_RUN]    = 1'b1;
        endcase
    end
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
    import pwr_state_pkg::*;
#(
    parameter int unsigned N_CORES   = 2,
    parameter int unsigned GRANT_DLY = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CORES-1:0] halt_req,
    input  logic               deep_halt_en,
    input  logic               deep_grant_en,
    input  logic               stop_clk_req,
    input  logic               ack_resp,
    input  logic               cpu_reset,
    input  logic               smi_ret,
    input  logic               smi_to_halt,
    input  logic               break_evt,
    input  logic               opp_done,
    output logic [4:0]         pstate,
    output logic               snoop_ok,
    output logic               ack_cycle_req,
    output logic               opp_req,
    output logic               opp_low
);
    ctl_s ctl_d, ctl_q;
    logic all_halted;
    logic tmr_start, tmr_run, tmr_expired;
    logic [PST_W-1:0] dec_state;
    logic [PST_W-1:0] prior_state;

    halt_join #(.N_CORES(N_CORES)) u_join (
        .req     (halt_req),
        .all_set (all_halted)
    );

    grant_timer #(.GRANT_DLY(GRANT_DLY)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    pstate_decode u_dec (
        .phase  (ctl_q.phase),
        .pstate (dec_state)
    );

    assign tmr_run = (ctl_q.phase == PH_WAIT);

    always_comb begin
        ctl_d     = ctl_q;
        tmr_start = 1'b0;
        case (ctl_q.phase)
            PH_RUN: begin
                if (cpu_reset) begin
                    ctl_d.ret_halt = 1'b0;
                end else if (stop_clk_req) begin
                    ctl_d.ret_halt = 1'b0;
                    ctl_d.phase    = PH_ACK;
                end else if (smi_ret) begin
                    ctl_d.phase = smi_to_halt ? PH_HALT : PH_RUN;
                end else if (all_halted) begin
                    ctl_d.phase = deep_halt_en ? PH_DH_IN : PH_HALT;
                end
            end
            PH_HALT: begin
                if (cpu_reset) begin
                    ctl_d.phase    = PH_RUN;
                    ctl_d.ret_halt = 1'b0;
                end else if (stop_clk_req) begin
                    ctl_d.ret_halt = 1'b1;
                    ctl_d.phase    = PH_ACK;
                end else if (smi_ret) begin
                    ctl_d.phase = smi_to_halt ? PH_HALT : PH_RUN;
                end else if (break_evt) begin
                    ctl_d.phase = PH_RUN;
                end
            end
            PH_DH_IN: begin
                if (opp_done) begin
                    ctl_d.phase = cpu_reset ? PH_DH_OUT : PH_DHALT;
                end
            end
            PH_DHALT: begin
                if (break_evt || cpu_reset) begin
                    ctl_d.phase = PH_DH_OUT;
                end
            end
            PH_DH_OUT: begin
                if (opp_done) begin
                    ctl_d.phase = PH_RUN;
                end
            end
            PH_ACK: begin
                if (cpu_reset) begin
                    ctl_d.phase    = PH_RUN;
                    ctl_d.ret_halt = 1'b0;
                end else if (!stop_clk_req) begin
                    ctl_d.phase = ctl_q.ret_halt ? PH_HALT : PH_RUN;
                end else if (ack_resp) begin
                    ctl_d.phase = PH_WAIT;
                    tmr_start   = 1'b1;
                end
            end
            PH_WAIT: begin
                if (cpu_reset) begin
                    ctl_d.phase    = PH_RUN;
                    ctl_d.ret_halt = 1'b0;
                end else if (!stop_clk_req) begin
                    ctl_d.phase = ctl_q.ret_halt ? PH_HALT : PH_RUN;
                end else if (ack_resp) begin
                    tmr_start = 1'b1;
                end else if (tmr_expired) begin
                    ctl_d.phase = deep_grant_en ? PH_DGRANT : PH_GRANT;
                end
            end
            PH_GRANT, PH_DGRANT: begin
                if (!stop_clk_req) begin
                    ctl_d.phase    = (ctl_q.ret_halt && !cpu_reset) ? PH_HALT : PH_RUN;
                    ctl_d.ret_halt = 1'b0;
                end else if (cpu_reset) begin
                    ctl_d.ret_halt = 1'b0;
                end
            end
            default: begin
                ctl_d.phase    = PH_RUN;
                ctl_d.ret_halt = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.phase    <= PH_RUN;
            ctl_q.ret_halt <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // while acknowledging or counting, the prior state stays visible
    always_comb begin
        prior_state = '0;
        prior_state[ctl_q.ret_halt ? ST_HALT : ST_RUN] = 1'b1;
    end

    assign pstate        = (ctl_q.phase == PH_ACK || ctl_q.phase == PH_WAIT) ? prior_state : dec_state;
    assign snoop_ok      = pstate[ST_HALT] | pstate[ST_DHALT];
    assign ack_cycle_req = (ctl_q.phase == PH_ACK);
    assign opp_req       = (ctl_q.phase == PH_DH_IN) || (ctl_q.phase == PH_DH_OUT);
    assign opp_low       = (ctl_q.phase == PH_DH_IN);
endmodule

// File: rtl/pwr_state_ctl_chk.sv
module pwr_state_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_clk_req,
    input logic       ack_resp,
    input logic       cpu_reset,
    input logic       opp_done,
    input logic [4:0] pstate,
    input logic       snoop_ok,
    input logic       ack_cycle_req,
    input logic       opp_req,
    input logic       opp_low
);
    // R12
    onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pstate) == 1);

    // R7
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_cycle_req && stop_clk_req && !ack_resp && !cpu_reset) |=> ack_cycle_req);

    // R4
    restore_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opp_req && !opp_low && !opp_done) |=> (opp_req && !opp_low && pstate[2]));

    // R3
    seq_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opp_req |-> snoop_ok);

    // R10
    grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pstate[3] || pstate[4]) && !stop_clk_req) |=> (pstate[0] || pstate[1]));

    // R11
    reset_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate[3] && cpu_reset && stop_clk_req) |=> pstate[3]);
endmodule

bind pwr_state_ctl pwr_state_ctl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_clk_req  (stop_clk_req),
    .ack_resp      (ack_resp),
    .cpu_reset     (cpu_reset),
    .opp_done      (opp_done),
    .pstate        (pstate),
    .snoop_ok      (snoop_ok),
    .ack_cycle_req (ack_cycle_req),
    .opp_req       (opp_req),
    .opp_low       (opp_low)
);

// File: tb/pwr_state_ctl_test.sv
`timescale 1ns/1ps
module pwr_state_ctl_test;
    localparam int unsigned NC = 2;
    localparam int unsigned GD = 20;
    localparam logic [4:0] S_RUN = 5'b00001, S_HALT = 5'b00010, S_DH = 5'b00100,
                           S_GR = 5'b01000, S_DGR = 5'b10000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0] halt_req = '0;
    logic deep_halt_en = 0, deep_grant_en = 0, stop_clk_req = 0, ack_resp = 0;
    logic cpu_reset = 0, smi_ret = 0, smi_to_halt = 0, break_evt = 0, opp_done = 0;
    logic [4:0] pstate;
    logic snoop_ok, ack_cycle_req, opp_req, opp_low;
    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    pwr_state_ctl #(.N_CORES(NC), .GRANT_DLY(GD)) uut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .deep_halt_en(deep_halt_en),
        .deep_grant_en(deep_grant_en), .stop_clk_req(stop_clk_req), .ack_resp(ack_resp),
        .cpu_reset(cpu_reset), .smi_ret(smi_ret), .smi_to_halt(smi_to_halt),
        .break_evt(break_evt), .opp_done(opp_done), .pstate(pstate), .snoop_ok(snoop_ok),
        .ack_cycle_req(ack_cycle_req), .opp_req(opp_req), .opp_low(opp_low)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one edge, then settle; R12 checked after every edge
    task automatic step();
        @(posedge clk);
        #1;
        chk("R12 onehot", $countones(pstate), 1);
    endtask

    task automatic run_grant(input bit from_halt, input bit deep, input int restart_off);
        logic [4:0] prior;
        prior = from_halt ? S_HALT : S_RUN;
        if (from_halt) begin
            smi_ret = 1; smi_to_halt = 1; step(); smi_ret = 0; smi_to_halt = 0;
            chk("R6 smi to halt", pstate, S_HALT);
        end
        deep_grant_en = deep;
        stop_clk_req = 1; step();
        chk("R7 ack raised", ack_cycle_req, 1);
        chk("R7 prior shown", pstate, prior);
        step(); step();
        chk("R7 ack held", ack_cycle_req, 1);
        ack_resp = 1; step(); ack_resp = 0;
        chk("R7 ack dropped", ack_cycle_req, 0);
        if (restart_off > 0) begin
            repeat (restart_off - 1) step();
            ack_resp = 1; step(); ack_resp = 0;
        end
        repeat (GD - 1) step();
        chk("R8 not yet granted", pstate, prior);
        step();
        chk(deep ? "R9 deep grant entry" : "R8 grant entry", pstate, deep ? S_DGR : S_GR);
        stop_clk_req = 0; step();
        chk("R10 release target", pstate, prior);
        deep_grant_en = 0;
        if (from_halt) begin
            break_evt = 1; step(); break_evt = 0;
            chk("R2 break leaves halt", pstate, S_RUN);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        chk("R1 state", pstate, S_RUN);
        chk("R1 snoop", snoop_ok, 0);
        chk("R1 ack", ack_cycle_req, 0);
        chk("R1 opp", opp_req, 0);

        // halt sweep over all request patterns and deep-halt settings
        for (int xen = 0; xen < 2; xen++) begin
            for (int pat = 0; pat < (1 << NC); pat++) begin
                deep_halt_en = xen[0];
                halt_req = pat[NC-1:0];
                step();
                if (pat != (1 << NC) - 1) begin
                    chk("R2 partial halt stays running", pstate, S_RUN);
                    chk("R5 no snoop running", snoop_ok, 0);
                    halt_req = '0; step();
                end else if (xen == 0) begin
                    chk("R2 all halted", pstate, S_HALT);
                    chk("R5 snoop in halt", snoop_ok, 1);
                    chk("R3 no opp request", opp_req, 0);
                    break_evt = 1; halt_req = '0; step(); break_evt = 0;
                    chk("R2 break exit", pstate, S_RUN);
                end else begin
                    chk("R3 entry shown halted", pstate, S_HALT);
                    chk("R3 low request", {opp_req, opp_low}, 2'b11);
                    step();
                    chk("R3 waits for done", {opp_req, opp_low}, 2'b11);
                    opp_done = 1; step(); opp_done = 0;
                    chk("R3 deep halt", pstate, S_DH);
                    chk("R3 request dropped", opp_req, 0);
                    chk("R5 snoop in deep halt", snoop_ok, 1);
                    break_evt = 1; halt_req = '0; step(); break_evt = 0;
                    chk("R4 restore request", {opp_req, opp_low}, 2'b10);
                    chk("R4 still deep", pstate, S_DH);
                    step(); step();
                    chk("R4 held until done", {opp_req, opp_low, pstate}, {2'b10, S_DH});
                    opp_done = 1; step(); opp_done = 0;
                    chk("R4 back to running", pstate, S_RUN);
                    chk("R4 request dropped", opp_req, 0);
                end
            end
        end
        deep_halt_en = 0;

        // management interrupt return
        smi_ret = 1; smi_to_halt = 0; step();
        chk("R6 return to running", pstate, S_RUN);
        smi_to_halt = 1; step();
        chk("R6 return to halt", pstate, S_HALT);
        smi_to_halt = 0; step(); smi_ret = 0;
        chk("R6 halt to running", pstate, S_RUN);

        // grant entry from both prior states, both variants
        for (int fh = 0; fh < 2; fh++)
            for (int dp = 0; dp < 2; dp++)
                run_grant(fh[0], dp[0], 0);

        // repeated response at every offset inside the window
        for (int off = 1; off < GD; off++) run_grant(off[0], 1'b0, off);

        // abort while waiting for response (from running)
        stop_clk_req = 1; step(); step();
        stop_clk_req = 0; step();
        chk("R10 abort before response", {ack_cycle_req, pstate}, {1'b0, S_RUN});
        // abort while counting (from halt)
        smi_ret = 1; smi_to_halt = 1; step(); smi_ret = 0; smi_to_halt = 0;
        stop_clk_req = 1; step(); ack_resp = 1; step(); ack_resp = 0;
        repeat (10) step();
        stop_clk_req = 0; step();
        chk("R10 abort while counting", pstate, S_HALT);
        repeat (GD + 2) step();
        chk("R10 no late grant", pstate, S_HALT);

        // processor reset in halt
        cpu_reset = 1; step(); cpu_reset = 0;
        chk("R11 reset from halt", pstate, S_RUN);
        // processor reset while counting
        stop_clk_req = 1; step(); ack_resp = 1; step(); ack_resp = 0;
        repeat (5) step();
        cpu_reset = 1; step(); cpu_reset = 0;
        chk("R11 reset while counting", {ack_cycle_req, pstate}, {1'b0, S_RUN});
        stop_clk_req = 0; step();
        // processor reset inside grant taken from halt
        smi_ret = 1; smi_to_halt = 1; step(); smi_ret = 0; smi_to_halt = 0;
        stop_clk_req = 1; step(); ack_resp = 1; step(); ack_resp = 0;
        repeat (GD) step();
        chk("R8 grant from halt", pstate, S_GR);
        cpu_reset = 1; step(); cpu_reset = 0;
        chk("R11 grant kept on reset", pstate, S_GR);
        step();
        chk("R11 grant still kept", pstate, S_GR);
        stop_clk_req = 0; step();
        chk("R11 release after reset to running", pstate, S_RUN);
        chk("R5 no snoop after release", snoop_ok, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule